// File: doc/BRIEF.md
# Integer Multiply/Divide Execution Unit

This block is an integer execution unit that sits beside a single-cycle ALU and handles 32-bit multiplication and division. Operations come in through a valid/ready issue port. Each operation carries an opcode, two operands and a tag. Results leave through one result port that carries a valid strobe, the data, the tag and an overflow flag.

Multiplies pass through a fixed-depth pipeline, so a new multiply can be accepted every cycle. Divides use an iterative radix-2 restoring engine. That engine runs one setup cycle, one iteration per operand bit and one sign-fix cycle, and the unit stays blocked for that whole time. The ready output carries the stall rules:
- A divide that follows a multiply waits until the multiply pipeline is empty.
- Nothing is accepted while a divide runs.

Because of these rules, results always leave in issue order. The ALU next to this unit never waits on it.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, `res_valid` and `res_ovf` are low and `iss_ready` is high.
- R2: Opcode 0 gives the low XLEN bits of the product. Opcode 1 gives the high XLEN bits of the signed product. Opcode 2 gives the high XLEN bits of the unsigned product. Codes 5, 6 and 7 act as opcode 0. A multiply result always has `res_ovf` low.
- R3: A multiply accepted in cycle c presents its result and tag in cycle c+MUL_STAGES (default 3), for exactly one cycle.
- R4: When no divide is running, a multiply is never refused. Multiplies issued on consecutive cycles produce results on consecutive cycles.
- R5: Opcode 3 is signed divide and opcode 4 is unsigned divide. Both return the quotient truncated toward zero. A divide accepted in cycle c presents its result in cycle c+XLEN+3 (35 by default).
- R6: From the cycle after a divide is accepted until the cycle its result is presented, `iss_ready` is low for every opcode. It is high again in the result cycle.
- R7: While any multiply is still in the pipeline, `iss_ready` is low when the presented opcode is a divide (3 or 4).
- R8: A divide by zero, signed or unsigned, returns all ones with `res_ovf` high.
- R9: A signed divide of the most negative value by minus one returns the most negative value (0x80000000) with `res_ovf` high.
- R10: At most one result is presented per cycle. Results leave in issue order. `res_ovf` is low whenever `res_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| iss_valid | input | 1 | An operation is presented |
| iss_ready | output | 1 | The presented operation is accepted this cycle |
| iss_op | input | 3 | Opcode, encoded as in R2 and R5 |
| iss_a | input | XLEN | First operand (dividend for divides) |
| iss_b | input | XLEN | Second operand (divisor for divides) |
| iss_tag | input | TAGW | Tag returned with the result |
| res_valid | output | 1 | Result present this cycle |
| res_data | output | XLEN | Result value |
| res_tag | output | TAGW | Tag of the operation the result belongs to |
| res_ovf | output | 1 | Divide by zero or signed overflow |

## Verification
The bench keeps a cycle index. Every accepted operation books an expected result into the slot of the cycle it is due: issue cycle plus 3 for multiplies, and issue cycle plus 35 for divides. Once per cycle, on the falling edge, the bench compares the result port with that slot. So an early, late, missing or extra result fails in the exact cycle it occurs.

The bench also predicts `iss_ready` before each issue from two things: the last multiply's drain window and the running divide's finish cycle. It compares this prediction with the port half a cycle before the accepting edge.

// File: rtl/muldiv_pkg.sv
package muldiv_pkg;

   typedef enum logic [2:0] {
      OPC_MUL_LO = 3'd0,
      OPC_MUL_HS = 3'd1,
      OPC_MUL_HU = 3'd2,
      OPC_DIV_S  = 3'd3,
      OPC_DIV_U  = 3'd4
   } opc_e;

   typedef struct packed {
      logic take_hi;
      logic sgn;
   } mulctl_t;

   typedef enum logic [1:0] {
      DV_IDLE  = 2'd0,
      DV_SETUP = 2'd1,
      DV_ITER  = 2'd2,
      DV_FIX   = 2'd3
   } dvstate_e;

   function automatic logic opc_is_div(input logic [2:0] op);
      return (op == OPC_DIV_S) || (op == OPC_DIV_U);
   endfunction

   // unused codes fall through to low-half multiply
   function automatic mulctl_t mul_decode(input logic [2:0] op);
      mulctl_t c;
      c.take_hi = (op == OPC_MUL_HS) || (op == OPC_MUL_HU);
      c.sgn     = (op == OPC_MUL_HS);
      return c;
   endfunction

endpackage

// File: rtl/muldiv_issue.sv
module muldiv_issue
   import muldiv_pkg::*;
(
   input  logic       iss_valid,
   input  logic [2:0] iss_op,
   input  logic       div_busy,
   input  logic       mul_busy,
   output logic       iss_ready,
   output logic       mul_go,
   output logic       div_go
);

   logic want_div;

   always_comb begin
      want_div  = opc_is_div(iss_op);
      // a running divide blocks everything; a divide waits for the multiply pipe to drain
      iss_ready = !div_busy && !(want_div && mul_busy);
      mul_go    = iss_valid && iss_ready && !want_div;
      div_go    = iss_valid && iss_ready &&  want_div;
   end

endmodule

// File: rtl/muldiv_mulpipe.sv
module muldiv_mulpipe
   import muldiv_pkg::*;
#(
   parameter int XLEN   = 32,
   parameter int TAGW   = 4,
   parameter int STAGES = 3
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            go,
   input  logic [2:0]      op,
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  logic [TAGW-1:0] tag,
   output logic            busy,
   output logic            out_valid,
   output logic [XLEN-1:0] out_data,
   output logic [TAGW-1:0] out_tag
);

   localparam int PW   = 2 * XLEN;
   localparam int LAST = STAGES - 1;

   // operand capture stage
   logic            s0_v;
   logic [XLEN-1:0] s0_a, s0_b;
   mulctl_t         s0_ctl;
   logic [TAGW-1:0] s0_tag;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s0_v <= 1'b0;
      else        s0_v <= go;
   end

   always_ff @(posedge clk) begin
      if (go) begin
         s0_a   <= a;
         s0_b   <= b;
         s0_ctl <= mul_decode(op);
         s0_tag <= tag;
      end
   end

   // the low PW bits of a product of extended operands match either signedness
   logic [PW-1:0] a_ext, b_ext, prod;

   always_comb begin
      a_ext = {{XLEN{s0_ctl.sgn & s0_a[XLEN-1]}}, s0_a};
      b_ext = {{XLEN{s0_ctl.sgn & s0_b[XLEN-1]}}, s0_b};
      prod  = a_ext * b_ext;
   end

   // product stages 1..LAST
   logic [LAST:1]   pv;
   logic [LAST:1]   phi;
   logic [PW-1:0]   pp   [LAST:1];
   logic [TAGW-1:0] ptag [LAST:1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pv <= '0;
      end else begin
         pv[1] <= s0_v;
         for (int k = 2; k <= LAST; k++) pv[k] <= pv[k-1];
      end
   end

   always_ff @(posedge clk) begin
      pp[1]   <= prod;
      phi[1]  <= s0_ctl.take_hi;
      ptag[1] <= s0_tag;
      for (int k = 2; k <= LAST; k++) begin
         pp[k]   <= pp[k-1];
         phi[k]  <= phi[k-1];
         ptag[k] <= ptag[k-1];
      end
   end

   always_comb begin
      busy      = s0_v | (|pv);
      out_valid = pv[LAST];
      out_data  = phi[LAST] ? pp[LAST][PW-1:XLEN] : pp[LAST][XLEN-1:0];
      out_tag   = ptag[LAST];
   end

endmodule

// File: rtl/muldiv_divider.sv
module muldiv_divider
   import muldiv_pkg::*;
#(
   parameter int XLEN = 32,
   parameter int TAGW = 4
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            go,
   input  logic [2:0]      op,
   input  logic [XLEN-1:0] a,
   input  logic [XLEN-1:0] b,
   input  logic [TAGW-1:0] tag,
   output logic            busy,
   output logic            out_valid,
   output logic [XLEN-1:0] out_data,
   output logic [TAGW-1:0] out_tag,
   output logic            out_ovf
);

   localparam int             CW      = $clog2(XLEN + 1);
   localparam logic [XLEN-1:0] MOST_NEG = {1'b1, {(XLEN-1){1'b0}}};

   dvstate_e        st;
   logic [CW-1:0]   cnt;
   logic            sgn_q, neg_q, dz_q, ov_q;
   logic [XLEN-1:0] opa_q, opb_q;
   logic [XLEN-1:0] quo, dsr, rem;
   logic [TAGW-1:0] tag_q;
   logic            vld_q;
   logic [XLEN-1:0] res_q;
   logic            rovf_q;

   // setup-cycle decode of the captured operands
   logic            a_neg, b_neg;
   logic [XLEN-1:0] mag_a, mag_b;

   always_comb begin
      a_neg = sgn_q & opa_q[XLEN-1];
      b_neg = sgn_q & opb_q[XLEN-1];
      mag_a = a_neg ? (~opa_q + 1'b1) : opa_q;
      mag_b = b_neg ? (~opb_q + 1'b1) : opb_q;
   end

   // one restoring step
   logic [XLEN:0] shifted, trial;

   always_comb begin
      shifted = {rem, quo[XLEN-1]};
      trial   = shifted - {1'b0, dsr};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st    <= DV_IDLE;
         cnt   <= '0;
         vld_q <= 1'b0;
      end else begin
         vld_q <= 1'b0;
         unique case (st)
            DV_IDLE:  if (go) st <= DV_SETUP;
            DV_SETUP: begin
               cnt <= CW'(XLEN);
               st  <= DV_ITER;
            end
            DV_ITER: begin
               cnt <= cnt - 1'b1;
               if (cnt == CW'(1)) st <= DV_FIX;
            end
            DV_FIX: begin
               vld_q <= 1'b1;
               st    <= DV_IDLE;
            end
            default: st <= DV_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      unique case (st)
         DV_IDLE: if (go) begin
            opa_q <= a;
            opb_q <= b;
            sgn_q <= (op == OPC_DIV_S);
            tag_q <= tag;
         end
         DV_SETUP: begin
            quo   <= mag_a;
            dsr   <= mag_b;
            rem   <= '0;
            neg_q <= a_neg ^ b_neg;
            dz_q  <= (opb_q == '0);
            ov_q  <= sgn_q && (opa_q == MOST_NEG) && (&opb_q);
         end
         DV_ITER: begin
            if (!trial[XLEN]) begin
               rem <= trial[XLEN-1:0];
               quo <= {quo[XLEN-2:0], 1'b1};
            end else begin
               rem <= shifted[XLEN-1:0];
               quo <= {quo[XLEN-2:0], 1'b0};
            end
         end
         DV_FIX: begin
            res_q  <= dz_q ? '1 : (neg_q ? (~quo + 1'b1) : quo);
            rovf_q <= dz_q | ov_q;
         end
         default: ;
      endcase
   end

   always_comb begin
      busy      = (st != DV_IDLE);
      out_valid = vld_q;
      out_data  = res_q;
      out_tag   = tag_q;
      out_ovf   = rovf_q;
   end

endmodule

// File: rtl/muldiv_unit.sv
module muldiv_unit
   import muldiv_pkg::*;
#(
   parameter int XLEN       = 32,
   parameter int TAGW       = 4,
   parameter int MUL_STAGES = 3
)(
   input  logic            clk,
   input  logic            rst_n,
   input  logic            iss_valid,
   output logic            iss_ready,
   input  logic [2:0]      iss_op,
   input  logic [XLEN-1:0] iss_a,
   input  logic [XLEN-1:0] iss_b,
   input  logic [TAGW-1:0] iss_tag,
   output logic            res_valid,
   output logic [XLEN-1:0] res_data,
   output logic [TAGW-1:0] res_tag,
   output logic            res_ovf
);

   generate
      if (XLEN < 4 || (XLEN % 2) != 0) begin : g_bad_xlen
         $error("muldiv_unit: XLEN must be even and at least 4");
      end
      if (MUL_STAGES < 2) begin : g_bad_stages
         $error("muldiv_unit: MUL_STAGES must be at least 2");
      end
      if (TAGW < 1) begin : g_bad_tag
         $error("muldiv_unit: TAGW must be at least 1");
      end
   endgenerate

   logic            mul_go, div_go;
   logic            mul_busy, div_busy;
   logic            mul_out_v, div_out_v;
   logic [XLEN-1:0] mul_out_d, div_out_d;
   logic [TAGW-1:0] mul_out_t, div_out_t;
   logic            div_out_o;

   muldiv_issue u_issue (
      .iss_valid (iss_valid),
      .iss_op    (iss_op),
      .div_busy  (div_busy),
      .mul_busy  (mul_busy),
      .iss_ready (iss_ready),
      .mul_go    (mul_go),
      .div_go    (div_go)
   );

   muldiv_mulpipe #(.XLEN(XLEN), .TAGW(TAGW), .STAGES(MUL_STAGES)) u_mul (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (mul_go),
      .op        (iss_op),
      .a         (iss_a),
      .b         (iss_b),
      .tag       (iss_tag),
      .busy      (mul_busy),
      .out_valid (mul_out_v),
      .out_data  (mul_out_d),
      .out_tag   (mul_out_t)
   );

   muldiv_divider #(.XLEN(XLEN), .TAGW(TAGW)) u_div (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (div_go),
      .op        (iss_op),
      .a         (iss_a),
      .b         (iss_b),
      .tag       (iss_tag),
      .busy      (div_busy),
      .out_valid (div_out_v),
      .out_data  (div_out_d),
      .out_tag   (div_out_t),
      .out_ovf   (div_out_o)
   );

   // the issue rules keep the two sources from ever presenting together
   always_comb begin
      res_valid = mul_out_v | div_out_v;
      res_ovf   = div_out_v & div_out_o;
      if (div_out_v) begin
         res_data = div_out_d;
         res_tag  = div_out_t;
      end else if (mul_out_v) begin
         res_data = mul_out_d;
         res_tag  = mul_out_t;
      end else begin
         res_data = '0;
         res_tag  = '0;
      end
   end

endmodule

// File: rtl/muldiv_unit_chk.sv
module muldiv_unit_chk
   import muldiv_pkg::*;
#(
   parameter int XLEN = 32,
   parameter int TAGW = 4
)(
   input logic            clk,
   input logic            rst_n,
   input logic            iss_valid,
   input logic            iss_ready,
   input logic [2:0]      iss_op,
   input logic [XLEN-1:0] iss_b,
   input logic            res_valid,
   input logic [XLEN-1:0] res_data,
   input logic [TAGW-1:0] res_tag,
   input logic            res_ovf,
   input logic            div_busy,
   input logic            mul_busy,
   input logic            mul_out_v,
   input logic            div_out_v
);

   logic       acc, acc_div;
   logic [7:0] pend;
   logic       zero_div;

   always_comb begin
      acc     = iss_valid && iss_ready;
      acc_div = acc && opc_is_div(iss_op);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend     <= '0;
         zero_div <= 1'b0;
      end else begin
         pend <= pend + {7'd0, acc} - {7'd0, res_valid};
         if (acc_div) zero_div <= (iss_b == '0);
      end
   end

   // R6: no issue of any kind while the divider runs
   a_r6_div_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      div_busy |-> !iss_ready);

   // R6: an accepted divide occupies the unit from the next cycle on
   a_r6_div_starts: assert property (@(posedge clk) disable iff (!rst_n)
      acc_div |=> (div_busy && !iss_ready));

   // R7: a divide waits for the multiply pipeline to empty
   a_r7_div_waits: assert property (@(posedge clk) disable iff (!rst_n)
      (opc_is_div(iss_op) && mul_busy) |-> !iss_ready);

   // R4: multiplies are only ever held back by a divide
   a_r4_mul_free: assert property (@(posedge clk) disable iff (!rst_n)
      (!div_busy && !opc_is_div(iss_op)) |-> iss_ready);

   // R10: one source at a time, no result without an accepted operation
   a_r10_one_source: assert property (@(posedge clk) disable iff (!rst_n)
      !(mul_out_v && div_out_v));

   a_r10_no_orphan: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |-> (pend != 8'd0));

   a_r10_ovf_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> !res_ovf);

   // R8: a zero divisor yields all ones with the flag raised
   a_r8_div_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (div_out_v && zero_div) |-> (res_ovf && (&res_data)));

   // R2: multiply results never raise the flag
   a_r2_mul_no_ovf: assert property (@(posedge clk) disable iff (!rst_n)
      mul_out_v |-> !res_ovf);

   // R10: the tag bus rests at zero between results
   a_r10_tag_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |-> (res_tag == '0));

endmodule

bind muldiv_unit muldiv_unit_chk #(.XLEN(XLEN), .TAGW(TAGW)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .iss_valid (iss_valid),
   .iss_ready (iss_ready),
   .iss_op    (iss_op),
   .iss_b     (iss_b),
   .res_valid (res_valid),
   .res_data  (res_data),
   .res_tag   (res_tag),
   .res_ovf   (res_ovf),
   .div_busy  (div_busy),
   .mul_busy  (mul_busy),
   .mul_out_v (mul_out_v),
   .div_out_v (div_out_v)
);

// File: tb/muldiv_unit_tb.sv
`timescale 1ns/1ps
module muldiv_unit_tb;

   localparam int XLEN    = 32;
   localparam int TAGW    = 4;
   localparam int MUL_LAT = 3;
   localparam int DIV_LAT = XLEN + 3;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            iss_valid = 1'b0;
   logic            iss_ready;
   logic [2:0]      iss_op = '0;
   logic [XLEN-1:0] iss_a = '0, iss_b = '0;
   logic [TAGW-1:0] iss_tag = '0;
   logic            res_valid;
   logic [XLEN-1:0] res_data;
   logic [TAGW-1:0] res_tag;
   logic            res_ovf;

   always #2 clk = ~clk;

   muldiv_unit #(.XLEN(XLEN), .TAGW(TAGW), .MUL_STAGES(MUL_LAT)) u_dut (
      .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready),
      .iss_op(iss_op), .iss_a(iss_a), .iss_b(iss_b), .iss_tag(iss_tag),
      .res_valid(res_valid), .res_data(res_data), .res_tag(res_tag), .res_ovf(res_ovf)
   );

   int total = 0, bad = 0;
   int cyc = 0;
   bit finished = 0;

   always @(posedge clk) if (rst_n) cyc <= cyc + 1;

   // expected results booked by due cycle
   logic            exp_v [64];
   logic [XLEN-1:0] exp_d [64];
   logic [TAGW-1:0] exp_t [64];
   logic            exp_o [64];
   string           exp_r [64];

   int div_free = 0;
   int mul_last = -1000;

   task automatic check(input bit ok, input string rq, input string what,
                        input logic [XLEN-1:0] act, input logic [XLEN-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s cycle %0d: actual=%h expected=%h", rq, what, cyc, act, exp);
      end
   endtask

   function automatic logic is_div(input logic [2:0] op);
      return (op == 3'd3) || (op == 3'd4);
   endfunction

   function automatic logic [XLEN:0] ref_calc(input logic [2:0] op,
                                              input logic [XLEN-1:0] a,
                                              input logic [XLEN-1:0] b);
      longint          sa, sb, sp;
      longint unsigned ua, ub, up;
      sa = longint'($signed(a));
      sb = longint'($signed(b));
      ua = {32'd0, a};
      ub = {32'd0, b};
      case (op)
         3'd1: begin sp = sa * sb; return {1'b0, sp[63:32]}; end
         3'd2: begin up = ua * ub; return {1'b0, up[63:32]}; end
         3'd3: begin
            if (b == '0) return {1'b1, 32'hFFFF_FFFF};
            if (a == 32'h8000_0000 && b == 32'hFFFF_FFFF) return {1'b1, 32'h8000_0000};
            sp = sa / sb;
            return {1'b0, sp[31:0]};
         end
         3'd4: begin
            if (b == '0) return {1'b1, 32'hFFFF_FFFF};
            up = ua / ub;
            return {1'b0, up[31:0]};
         end
         default: begin up = ua * ub; return {1'b0, up[31:0]}; end
      endcase
   endfunction

   task automatic check_outputs();
      int s;
      s = cyc % 64;
      check(res_valid == exp_v[s], "R10", "res_valid", {31'd0, res_valid}, {31'd0, exp_v[s]});
      if (exp_v[s] && res_valid) begin
         check(res_data == exp_d[s], exp_r[s], "res_data", res_data, exp_d[s]);
         check(res_tag == exp_t[s], exp_r[s], "res_tag", {28'd0, res_tag}, {28'd0, exp_t[s]});
         check(res_ovf == exp_o[s], exp_r[s], "res_ovf", {31'd0, res_ovf}, {31'd0, exp_o[s]});
      end
      if (!res_valid)
         check(res_ovf == 1'b0, "R10", "res_ovf idle", {31'd0, res_ovf}, 32'd0);
      exp_v[s] = 1'b0;
   endtask

   // one cycle: check what is due, present an operation, compare ready with the model
   task automatic step(input logic v, input logic [2:0] op, input logic [XLEN-1:0] a,
                       input logic [XLEN-1:0] b, input logic [TAGW-1:0] tag, input string rq);
      logic          pred;
      logic [XLEN:0] r;
      string         rl;
      int            s;
      @(negedge clk);
      check_outputs();
      iss_valid = v; iss_op = op; iss_a = a; iss_b = b; iss_tag = tag;
      #1;
      pred = (cyc >= div_free) && !(is_div(op) && (cyc <= mul_last + MUL_LAT));
      rl = (cyc < div_free) ? "R6" : (is_div(op) ? "R7" : "R4");
      check(iss_ready == pred, rl, "iss_ready", {31'd0, iss_ready}, {31'd0, pred});
      if (v && pred) begin
         r = ref_calc(op, a, b);
         s = (cyc + (is_div(op) ? DIV_LAT : MUL_LAT)) % 64;
         exp_v[s] = 1'b1;
         exp_d[s] = r[XLEN-1:0];
         exp_o[s] = r[XLEN];
         exp_t[s] = tag;
         exp_r[s] = rq;
         if (is_div(op)) div_free = cyc + DIV_LAT;
         else            mul_last = cyc;
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 3'd0, '0, '0, '0, "R10");
   endtask

   task automatic summary();
      $display("  test done: total=%0d bad=%0d", total, bad);
   endtask

   initial begin
      #(4 * 100000);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog expired at cycle %0d: actual=running expected=done", cyc);
         summary();
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < 64; i++) exp_v[i] = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1: state right after reset
      check(res_valid == 1'b0, "R1", "res_valid after reset", {31'd0, res_valid}, 32'd0);
      check(res_ovf == 1'b0, "R1", "res_ovf after reset", {31'd0, res_ovf}, 32'd0);
      check(iss_ready == 1'b1, "R1", "iss_ready after reset", {31'd0, iss_ready}, 32'd1);

      // R4 R3 R2: back-to-back multiplies, each opcode
      step(1, 3'd0, 32'h0001_2345, 32'h0000_6789, 4'd1, "R4");
      step(1, 3'd1, 32'hFFFF_FFFE, 32'h0000_0003, 4'd2, "R4");
      step(1, 3'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd3, "R4");
      step(1, 3'd1, 32'h8000_0000, 32'h8000_0000, 4'd4, "R4");
      step(1, 3'd0, 32'hDEAD_BEEF, 32'h1234_5678, 4'd5, "R4");
      step(1, 3'd2, 32'h0000_0000, 32'h1234_5678, 4'd6, "R4");
      idle(4);

      // R2: unused codes act as low-half multiply
      step(1, 3'd5, 32'h0000_1000, 32'h0010_0001, 4'd7, "R2");
      step(1, 3'd6, 32'hFFFF_FFFF, 32'h0000_0002, 4'd8, "R2");
      step(1, 3'd7, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 4'd9, "R2");
      idle(4);

      // R5 R6: signed divide, then a multiply refused while it runs
      step(1, 3'd3, 32'hFFFF_FF9C, 32'd7, 4'd10, "R5");
      step(1, 3'd0, 32'd3, 32'd4, 4'd11, "R6");
      idle(DIV_LAT + 2);

      // R7: divide right behind a multiply waits for the drain
      step(1, 3'd0, 32'd9, 32'd9, 4'd12, "R3");
      for (int i = 0; i < 5; i++) step(1, 3'd4, 32'd1000, 32'd7, 4'd13, "R5");
      idle(DIV_LAT + 2);

      // R8 R9: corner divides
      step(1, 3'd3, 32'h0000_1234, 32'd0, 4'd14, "R8");
      idle(DIV_LAT + 1);
      step(1, 3'd4, 32'hFFFF_0000, 32'd0, 4'd15, "R8");
      idle(DIV_LAT + 1);
      step(1, 3'd3, 32'h8000_0000, 32'hFFFF_FFFF, 4'd0, "R9");
      idle(DIV_LAT + 1);
      step(1, 3'd3, 32'h8000_0000, 32'd1, 4'd1, "R5");
      idle(DIV_LAT + 1);
      step(1, 3'd4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd2, "R5");
      idle(DIV_LAT + 1);

      // random mix
      for (int i = 0; i < 4000; i++) begin
         logic [2:0]      op;
         logic [XLEN-1:0] a, b;
         int              r, pick;
         r = $urandom % 20;
         if (r < 11)      op = 3'($urandom % 3);
         else if (r < 13) op = (($urandom % 2) == 0) ? 3'd3 : 3'd4;
         else if (r < 14) op = 3'(5 + ($urandom % 3));
         else             op = 3'd0;
         a = $urandom;
         b = $urandom;
         pick = $urandom % 8;
         if (pick == 0) b = 32'd0;
         else if (pick == 1) b = 32'hFFFF_FFFF;
         else if (pick == 2) begin a = 32'h8000_0000; b = 32'hFFFF_FFFF; end
         else if (pick == 3) b = b >> ($urandom % 31);
         step((r < 14), op, a, b, 4'($urandom), is_div(op) ? "R5" : "R2 R3");
      end
      idle(DIV_LAT + 4);

      finished = 1;
      summary();
      $finish;
   end

endmodule